// File: doc/BRIEF.md
# SPI command engine with clear-to-send polling

This block is an SPI master sequencer for a radio-style peripheral that accepts a command frame and then needs time before it can answer. The host places up to 16 command bytes on a flat input bus and sets a transmit count, a receive count, an idle gap length and a poll limit. It then pulses start. The engine selects the peripheral and shifts the command out. It releases select and waits for the idle gap. It then runs poll transactions until the peripheral returns the ready byte 0xFF.

A poll transaction sends the buffer-read opcode 0x44 and then a 0xFF filler byte, and it captures the status byte during that filler byte. On a ready status, select stays asserted and the response bytes are clocked in within that same transaction, using 0xFF filler. A mode input skips polling altogether. An optional poll limit turns a peripheral that never becomes ready into a timeout flag rather than a hang. Command content, such as the layout of a property write (opcode, group, value count, first index, then the value bytes most significant first), is left to the host. The engine only shifts the bytes.

Top module: `spi_cts_engine`

## Requirements
- R1: After reset, cs_no is 1, sclk_o is 0, busy_o is 0, done_o is 0 and timeout_o is 0.
- R2: SPI mode 0, MSB first. SCLK idles low and is low whenever cs_no is 1. MOSI changes only at a falling SCLK edge or before the first rising edge. MISO is sampled at rising edges. Within a byte, rising edges are DIV clock cycles apart.
- R3: In the command phase, cs_no goes low and exactly tx_count_i bytes (valid 1..16) are shifted out. Byte i is tx_data_i[8i+7:8i] and byte 0 goes first. cs_no then goes high. cs_no does not change while a byte is shifting.
- R4: When no_cts_i is 0, every poll transaction comes after at least gap_cycles_i clock cycles with cs_no high. In a poll transaction, cs_no goes low, 0x44 is sent, and then 0xFF is sent while one status byte is captured.
- R5: A status byte other than 0xFF ends the poll transaction with cs_no high. Another poll transaction follows after the gap.
- R6: A status byte of 0xFF keeps cs_no low. rx_count_i bytes (valid 0..16) are then clocked in, each sent as 0xFF filler, and response byte i is stored in rx_data_o[8i+7:8i]. cs_no goes high only after the last response byte. With rx_count_i = 0, cs_no goes high right after the status byte.
- R7: With no_cts_i = 1, the engine finishes right after cs_no goes high at the end of the command, and no poll transaction takes place.
- R8: With max_polls_i nonzero, the engine sets timeout_o, pulses done_o and returns to idle after max_polls_i poll transactions that all returned a not-ready status. With max_polls_i = 0, polling is unlimited. Each accepted start clears timeout_o.
- R9: busy_o is 1 from the cycle after an accepted start until done_o is pulsed. done_o is high for exactly one cycle. A start pulse while busy_o is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| no_cts_i | input | 1 | 1 = skip clear-to-send polling |
| tx_data_i | input | 128 | Command bytes, byte i at [8i+7:8i] |
| tx_count_i | input | 5 | Number of command bytes, 1..16 |
| rx_count_i | input | 5 | Number of response bytes, 0..16 |
| gap_cycles_i | input | 16 | Minimum idle cycles before each poll |
| max_polls_i | input | 8 | Poll limit, 0 = unlimited |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Last operation ended on the poll limit |
| rx_data_o | output | 128 | Response bytes, byte i at [8i+7:8i] |
| cs_no | output | 1 | Peripheral select, active low |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data to the peripheral |
| miso_i | input | 1 | Serial data from the peripheral |

## Verification
Assertions in the RTL check several rules on every cycle: SCLK stays low while select is high, select stays stable while a byte shifts, MOSI moves only on a falling SCLK edge, done_o is a single-cycle pulse, a rising timeout is followed by done, and a start during busy leaves the engine busy. Other behaviour can only be shown by the bench's scenarios, with a behavioural peripheral model that records every transaction. These are the byte order and contents of each frame, the retry count for a given sequence of status bytes, the idle gap between transactions, the response storage, the no-poll mode, and the timeout after a fixed number of failed polls.

// File: rtl/spi_cts_pkg.sv
package spi_cts_pkg;
  localparam logic [7:0] OPC_READ_BUF = 8'h44;
  localparam logic [7:0] FILL_BYTE    = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_GAP, ST_POLL_OP, ST_POLL_ST, ST_RESP, ST_FIN
  } eng_state_e;
endpackage

// File: rtl/spi_byte_xfer.sv
module spi_byte_xfer #(
  parameter int DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic [7:0] byte_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic [2:0]    bit_q;
  logic          sclk_q, busy_q, done_q;
  logic [7:0]    tx_sh, rx_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; bit_q <= '0; sclk_q <= 1'b0; busy_q <= 1'b0;
      done_q <= 1'b0; tx_sh <= '0; rx_sh <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (go_i) begin
          busy_q <= 1'b1; tx_sh <= byte_i; cnt_q <= '0; bit_q <= '0; sclk_q <= 1'b0;
        end
      end else if (cnt_q == CW'(HALF - 1)) begin
        cnt_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_sh  <= {rx_sh[6:0], miso_i};
        end else begin
          sclk_q <= 1'b0;
          if (bit_q == 3'd7) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
            tx_sh <= {tx_sh[6:0], 1'b0};
          end
        end
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = tx_sh[7];
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rx_o   = rx_sh;

  // R2: data moves only on the falling clock edge inside a byte
  a_r2_mosi_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) && !$fell(sclk_q)) |-> $stable(mosi_o));
endmodule

// File: rtl/spi_gap_timer.sv
module spi_gap_timer #(
  parameter int GAP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [GAP_W-1:0] cycles_i,
  output logic             expired_o
);
  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= cycles_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - GAP_W'(1);
  end

  assign expired_o = (cnt_q == '0) && !load_i;
endmodule

// File: rtl/spi_cts_engine.sv
module spi_cts_engine #(
  parameter int DIV       = 4,
  parameter int MAX_BYTES = 16,
  parameter int GAP_W     = 16,
  parameter int POLL_W    = 8,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1),
  localparam int BUF_W    = MAX_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              no_cts_i,
  input  logic [BUF_W-1:0]  tx_data_i,
  input  logic [CNT_W-1:0]  tx_count_i,
  input  logic [CNT_W-1:0]  rx_count_i,
  input  logic [GAP_W-1:0]  gap_cycles_i,
  input  logic [POLL_W-1:0] max_polls_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic [BUF_W-1:0]  rx_data_o,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  import spi_cts_pkg::*;

  eng_state_e        state;
  logic              cs_n_q, busy_q, done_q, to_q, no_cts_q;
  logic              go_q, gap_load;
  logic [7:0]        go_byte;
  logic [CNT_W-1:0]  idx, tx_cnt_q, rx_cnt_q;
  logic [POLL_W-1:0] polls, max_q;
  logic [GAP_W-1:0]  gap_q;
  logic [BUF_W-1:0]  tx_q, rx_q;
  logic              byte_busy, byte_done, gap_done;
  logic [7:0]        byte_rx;

  spi_byte_xfer #(.DIV(DIV)) u_xfer (
    .clk_i, .rst_ni, .go_i(go_q), .byte_i(go_byte), .miso_i,
    .sclk_o, .mosi_o, .busy_o(byte_busy), .done_o(byte_done), .rx_o(byte_rx)
  );

  spi_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk_i, .rst_ni, .load_i(gap_load), .cycles_i(gap_q), .expired_o(gap_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE; cs_n_q <= 1'b1; busy_q <= 1'b0; done_q <= 1'b0;
      to_q <= 1'b0; no_cts_q <= 1'b0; go_q <= 1'b0; gap_load <= 1'b0;
      go_byte <= '0; idx <= '0; tx_cnt_q <= '0; rx_cnt_q <= '0;
      polls <= '0; max_q <= '0; gap_q <= '0; tx_q <= '0; rx_q <= '0;
    end else begin
      go_q <= 1'b0; done_q <= 1'b0; gap_load <= 1'b0;
      unique case (state)
        ST_IDLE: if (start_i) begin
          tx_q <= tx_data_i; tx_cnt_q <= tx_count_i; rx_cnt_q <= rx_count_i;
          gap_q <= gap_cycles_i; max_q <= max_polls_i; no_cts_q <= no_cts_i;
          busy_q <= 1'b1; to_q <= 1'b0; polls <= '0; cs_n_q <= 1'b0;
          go_q <= 1'b1; go_byte <= tx_data_i[7:0]; idx <= CNT_W'(1);
          state <= ST_CMD;
        end
        ST_CMD: if (byte_done) begin
          if (idx == tx_cnt_q) begin
            cs_n_q <= 1'b1;
            if (no_cts_q) state <= ST_FIN;
            else begin gap_load <= 1'b1; state <= ST_GAP; end
          end else begin
            go_q <= 1'b1; go_byte <= tx_q[int'(idx)*8 +: 8]; idx <= idx + CNT_W'(1);
          end
        end
        ST_GAP: if (gap_done) begin
          if (max_q != '0 && polls == max_q) begin
            to_q <= 1'b1; state <= ST_FIN;
          end else begin
            polls <= polls + POLL_W'(1); cs_n_q <= 1'b0;
            go_q <= 1'b1; go_byte <= OPC_READ_BUF; state <= ST_POLL_OP;
          end
        end
        ST_POLL_OP: if (byte_done) begin
          go_q <= 1'b1; go_byte <= FILL_BYTE; state <= ST_POLL_ST;
        end
        ST_POLL_ST: if (byte_done) begin
          if (byte_rx == FILL_BYTE) begin
            if (rx_cnt_q == '0) begin
              cs_n_q <= 1'b1; state <= ST_FIN;
            end else begin
              idx <= '0; go_q <= 1'b1; go_byte <= FILL_BYTE; state <= ST_RESP;
            end
          end else begin
            cs_n_q <= 1'b1; gap_load <= 1'b1; state <= ST_GAP;
          end
        end
        ST_RESP: if (byte_done) begin
          rx_q[int'(idx)*8 +: 8] <= byte_rx;
          if (idx + CNT_W'(1) == rx_cnt_q) begin
            cs_n_q <= 1'b1; state <= ST_FIN;
          end else begin
            idx <= idx + CNT_W'(1); go_q <= 1'b1; go_byte <= FILL_BYTE;
          end
        end
        ST_FIN: begin
          busy_q <= 1'b0; done_q <= 1'b1; state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cs_no     = cs_n_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign timeout_o = to_q;
  assign rx_data_o = rx_q;

  a_r2_sclk_low_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_q |-> !sclk_o);
  a_r3_cs_stable_in_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_busy |-> $stable(cs_n_q));
  a_r8_timeout_then_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(to_q) |=> done_q);
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r9_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && state != ST_FIN) |=> busy_q);
endmodule

// File: tb/tb_spi_cts_engine.sv
module tb_spi_cts_engine;
  localparam int DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, no_cts = 1'b0;
  logic [127:0] tx_data = '0;
  logic [4:0] tx_count = 5'd1, rx_count = 5'd0;
  logic [15:0] gap_cycles = 16'd0;
  logic [7:0] max_polls = 8'd0;
  logic busy, done, timeout, cs_n, sclk, mosi;
  logic miso = 1'b0;
  logic [127:0] rx_data;

  always #2.5 clk = ~clk;

  spi_cts_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .no_cts_i(no_cts),
    .tx_data_i(tx_data), .tx_count_i(tx_count), .rx_count_i(rx_count),
    .gap_cycles_i(gap_cycles), .max_polls_i(max_polls),
    .busy_o(busy), .done_o(done), .timeout_o(timeout), .rx_data_o(rx_data),
    .cs_no(cs_n), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  logic [7:0] tb_bytes [0:63][0:19];
  int tb_len [0:63];
  int gap_of [0:63];
  int tb_ntr = 0, cur = 0, bcnt = 0, hi_run = 0, last_rise = 0;
  logic [7:0] in_sh = '0, out_sh = '0;
  logic [7:0] stat [0:15];
  int nstat = 0;
  logic [7:0] resp [0:15];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] slave_byte(input int t, input int k);
    if (t == 0 || k == 0) return 8'h00;
    if (k == 1) return (t - 1 < nstat) ? stat[t-1] : 8'h00;
    if (k - 2 < 16) return resp[k-2];
    return 8'h00;
  endfunction

  // behavioural peripheral: records every byte of every select period
  always @(negedge cs_n) begin
    cur = (tb_ntr < 64) ? tb_ntr : 63;
    tb_len[cur] = 0; bcnt = 0;
    out_sh = slave_byte(cur, 0); miso = out_sh[7];
  end
  always @(posedge cs_n) if (rst_n) tb_ntr++;
  always @(posedge sclk) begin
    if (bcnt != 0) chk("R2 sclk period", cyc - last_rise, DIV);
    last_rise = cyc;
    in_sh = {in_sh[6:0], mosi};
    bcnt++;
    if (bcnt == 8) begin
      if (tb_len[cur] < 20) tb_bytes[cur][tb_len[cur]] = in_sh;
      tb_len[cur]++; bcnt = 0;
    end
  end
  always @(negedge sclk) begin
    if (bcnt == 0) out_sh = slave_byte(cur, tb_len[cur]);
    else out_sh = {out_sh[6:0], 1'b0};
    miso = out_sh[7];
  end

  always @(posedge clk) cyc++;
  // per-clock mode 0 check and gap measurement
  always @(negedge clk) if (rst_n) begin
    if (cs_n) begin
      if (sclk) begin checks++; errors++; $display("FAIL R2 sclk high while deselected actual=1 expected=0"); end
      hi_run++;
    end else if (hi_run != 0) begin
      if (tb_ntr < 64) gap_of[tb_ntr] = hi_run;
      hi_run = 0;
    end
  end

  bit hung = 0;
  task automatic run_op(input int ntx, input int nrx, input bit nc, input int gap, input int mp,
                        input bit poke_busy);
    @(negedge clk);
    tx_count = 5'(ntx); rx_count = 5'(nrx); no_cts = nc;
    gap_cycles = 16'(gap); max_polls = 8'(mp);
    tb_ntr = 0; hi_run = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 busy after start", int'(busy), 1);
    if (poke_busy) begin
      repeat (5) @(negedge clk);
      start = 1'b1; no_cts = 1'b1; tx_count = 5'd1;
      @(negedge clk);
      start = 1'b0;
      chk("R9 start ignored keeps busy", int'(busy), 1);
    end
    for (int i = 0; i < 20000; i++) begin
      if (done) break;
      if (!busy) begin
        chk("R9 busy held until done", 0, 1);
        break;
      end
      @(negedge clk);
    end
    if (!done) begin
      hung = 1; checks++; errors++;
      $display("FAIL R9 watchdog actual=0 expected=1");
    end
    chk("R9 busy low at done", int'(busy), 0);
    @(negedge clk);
    chk("R9 done single cycle", int'(done), 0);
  endtask

  task automatic chk_poll(input int t, input int len, input string req);
    chk({req, " poll length"}, tb_len[t], len);
    chk("R4 poll opcode", int'(tb_bytes[t][0]), 8'h44);
    chk("R4 poll filler", int'(tb_bytes[t][1]), 8'hFF);
    chk("R4 gap before poll", int'(gap_of[t] >= int'(gap_cycles)), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 cs_no", int'(cs_n), 1);
    chk("R1 sclk", int'(sclk), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 timeout", int'(timeout), 0);
    rst_n = 1'b1;

    // normal: two not-ready polls then ready, two response bytes, start poked while busy
    tx_data = '0; tx_data[7:0] = 8'h11; tx_data[15:8] = 8'h22; tx_data[23:16] = 8'h33;
    stat[0] = 8'h00; stat[1] = 8'h80; stat[2] = 8'hFF; nstat = 3;
    resp[0] = 8'hA5; resp[1] = 8'h3C;
    if (!hung) run_op(3, 2, 1'b0, 10, 0, 1'b1);
    chk("R3 transaction count", tb_ntr, 4);
    chk("R3 cmd length", tb_len[0], 3);
    chk("R3 cmd byte0", int'(tb_bytes[0][0]), 8'h11);
    chk("R3 cmd byte1", int'(tb_bytes[0][1]), 8'h22);
    chk("R3 cmd byte2", int'(tb_bytes[0][2]), 8'h33);
    chk_poll(1, 2, "R5");
    chk_poll(2, 2, "R5");
    chk_poll(3, 4, "R6");
    chk("R6 filler byte", int'(tb_bytes[3][2]), 8'hFF);
    chk("R6 filler byte", int'(tb_bytes[3][3]), 8'hFF);
    chk("R6 resp0", int'(rx_data[7:0]), 8'hA5);
    chk("R6 resp1", int'(rx_data[15:8]), 8'h3C);
    chk("R8 no timeout", int'(timeout), 0);

    // no-CTS mode with a full 16-byte command
    for (int i = 0; i < 16; i++) tx_data[8*i +: 8] = 8'(8'hC0 + 8'(i * 7));
    nstat = 0;
    if (!hung) run_op(16, 3, 1'b1, 4, 0, 1'b0);
    chk("R7 single transaction", tb_ntr, 1);
    chk("R7 cmd length", tb_len[0], 16);
    for (int i = 0; i < 16; i++) chk("R3 long cmd byte", int'(tb_bytes[0][i]), int'(8'(8'hC0 + 8'(i * 7))));

    // immediate ready, no response bytes
    tx_data[7:0] = 8'h5A;
    stat[0] = 8'hFF; nstat = 1;
    if (!hung) run_op(1, 0, 1'b0, 0, 0, 1'b0);
    chk("R6 rx0 transaction count", tb_ntr, 2);
    chk("R3 single cmd byte", int'(tb_bytes[0][0]), 8'h5A);
    chk_poll(1, 2, "R6 rx0");

    // timeout after three not-ready polls
    stat[0] = 8'h00; stat[1] = 8'hFE; stat[2] = 8'h7F; stat[3] = 8'hFF; nstat = 4;
    if (!hung) run_op(2, 1, 1'b0, 6, 3, 1'b0);
    chk("R8 timeout set", int'(timeout), 1);
    chk("R8 poll transactions", tb_ntr, 4);
    chk_poll(3, 2, "R8");

    // full response buffer; start clears timeout
    stat[0] = 8'h7F; stat[1] = 8'hFF; nstat = 2;
    for (int i = 0; i < 16; i++) resp[i] = 8'(8'h0F + 8'(i * 13));
    if (!hung) run_op(1, 16, 1'b0, 3, 5, 1'b0);
    chk("R8 timeout cleared", int'(timeout), 0);
    chk("R6 rx16 transaction count", tb_ntr, 3);
    chk_poll(2, 18, "R6");
    for (int i = 0; i < 16; i++) chk("R6 resp byte", int'(rx_data[8*i +: 8]), int'(8'(8'h0F + 8'(i * 13))));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    checks++; errors++;
    $display("FAIL R9 global watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule